// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned 32-bit operands over many clock cycles and returns the full 64-bit product. A single 64-bit working register serves two purposes. Its low half starts out holding the multiplier, and its high half builds up the partial product. On each iteration the block does two things:

- It looks at bit 0 of the working register. If that bit is set, it adds the multiplicand into the high half using a 32-bit adder.
- It shifts the whole register right by one. The adder carry enters at the top bit.

After 32 iterations the multiplier bits have all been used and the register holds the product.

A client raises `start` for one cycle while the block is idle. The operands are captured on that edge and `busy` rises. `done` pulses for one cycle after the last iteration. The product is read as a high word and a low word, and it stays put until the next accepted start. A start that arrives while the block is busy has no effect.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is active and directly after it, `busy` and `done` are 0 and `hi` and `lo` are 0.
- R2: A start seen while `busy` is 0 is accepted on that clock edge. In the following cycle `busy` is 1, `lo` equals the multiplier operand and `hi` is 0.
- R3: After an accepted start, `busy` stays 1 for exactly 32 cycles. On the edge that ends the 32nd iteration, `busy` drops and `done` becomes 1 for exactly one cycle. `done` is never 1 while `busy` is 1.
- R4: In the cycle where `done` is 1, the concatenation {`hi`,`lo`} equals the full 64-bit unsigned product of the accepted operands, with no carry lost, including for all-ones operands.
- R5: A start raised while `busy` is 1 is ignored. The running operation keeps its operands and its timing.
- R6: While `busy` is 0 and no start is raised, `hi` and `lo` hold their values, whatever the operand inputs do.
- R7: Each iteration replaces the register P = {`hi`,`lo`} with ((P>>32) + (P[0] ? multiplicand : 0)) · 2^31 + (P mod 2^32) >> 1, where the 33-bit sum keeps its carry.
- R8: A start raised in the same cycle that `done` is 1 is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication |
| mcandIn | input | 32 | Multiplicand operand |
| mplierIn | input | 32 | Multiplier operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | 32 | Upper word of the working register / product |
| lo | output | 32 | Lower word of the working register / product |

## Verification
The assertions check on every cycle:

- the load values after an accepted start;
- the length of the busy window and the shape of the done pulse;
- that a start during busy does not end the run;
- that the product presented with `done` matches the operands captured at the start;
- that the outputs stay unchanged while the block is idle.

The bench's behavioural reference model follows the working register through every iteration, which shows the step arithmetic itself. Only the scenarios can show three further things: that all-ones operands keep their carry, that a start raised in the middle of a run leaves the result unchanged, and that a start raised in the done cycle is accepted.

// File: rtl/mul_pkg.sv
package mul_pkg;

  // Control states
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture operands, clear upper half
    logic step;  // one conditional-add + shift iteration
  } mulStrobe_t;

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 1);

  mulState_t       state;
  logic [CNT_W-1:0] iterCnt;
  logic            doneQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST_ITER) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
  end

  assign busy = (state == ST_RUN);
  assign done = doneQ;

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mulStrobe_t       strobe,
  input  logic [WIDTH-1:0] mcandIn,
  input  logic [WIDTH-1:0] mplierIn,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    prodQ;
  logic [WIDTH-1:0] mcandQ;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sumWide;   // carry kept as extra bit
  logic [PW-1:0]    prodNext;

  always_comb begin
    addend   = prodQ[0] ? mcandQ : '0;
    sumWide  = {1'b0, prodQ[PW-1:WIDTH]} + {1'b0, addend};
    prodNext = {sumWide, prodQ[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prodQ  <= '0;
      mcandQ <= '0;
    end else if (strobe.load) begin
      prodQ  <= {{WIDTH{1'b0}}, mplierIn};
      mcandQ <= mcandIn;
    end else if (strobe.step) begin
      prodQ <= prodNext;
    end
  end

  assign prodHi = prodQ[PW-1:WIDTH];
  assign prodLo = prodQ[WIDTH-1:0];

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] mcandIn,
  input  logic [WIDTH-1:0] mplierIn,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);

  mulStrobe_t strobe;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .mcandIn  (mcandIn),
    .mplierIn (mplierIn),
    .prodHi   (hi),
    .prodLo   (lo)
  );

endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] mcandIn,
  input logic [WIDTH-1:0] mplierIn,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo
);

  localparam int CW = $clog2(WIDTH + 1) + 1;

  logic [CW-1:0]      busyCnt;
  logic [WIDTH-1:0]   capA;
  logic [WIDTH-1:0]   capB;
  logic [2*WIDTH-1:0] expProd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyCnt <= '0;
      capA    <= '0;
      capB    <= '0;
    end else begin
      busyCnt <= busy ? busyCnt + 1'b1 : '0;
      if (start && !busy) begin
        capA <= mcandIn;
        capB <= mplierIn;
      end
    end
  end

  assign expProd = {{WIDTH{1'b0}}, capA} * {{WIDTH{1'b0}}, capB};

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && lo == $past(mplierIn) && hi == '0));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && $past(busyCnt) == CW'(WIDTH - 1)));

  p_busy_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busyCnt < CW'(WIDTH)));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({hi, lo} == expProd));

  p_ignore_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && busyCnt != CW'(WIDTH - 1)) |=> busy);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hi) && $stable(lo)));

endmodule

bind shift_add_mul mul_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .mcandIn  (mcandIn),
  .mplierIn (mplierIn),
  .busy     (busy),
  .done     (done),
  .hi       (hi),
  .lo       (lo)
);

// File: tb/tb_shift_add_mul.sv
`timescale 1ns/1ps
module tb_shift_add_mul;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] mcandIn = '0;
  logic [31:0] mplierIn = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  shift_add_mul #(.WIDTH(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcandIn(mcandIn), .mplierIn(mplierIn),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  // Behavioural reference model
  logic        mBusy = 1'b0;
  logic        mDone = 1'b0;
  logic [63:0] mProd = '0;
  logic [63:0] mMcand = '0;
  int          mIter = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mBusy = 1'b0; mDone = 1'b0; mProd = '0; mMcand = '0; mIter = 0;
    end else begin
      mDone = 1'b0;
      if (mBusy) begin
        logic [63:0] upper;
        upper = mProd >> 32;
        if (mProd[0]) upper = upper + mMcand;
        mProd = (upper << 31) + ((mProd & 64'hFFFF_FFFF) >> 1);
        mIter = mIter + 1;
        if (mIter == 32) begin
          mBusy = 1'b0;
          mDone = 1'b1;
        end
      end else if (start) begin
        mProd  = {32'd0, mplierIn};
        mMcand = {32'd0, mcandIn};
        mBusy  = 1'b1;
        mIter  = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison with the model (R3 handshake, R7 register)
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == mBusy, "R3", "busy vs model", 64'(busy), 64'(mBusy));
      check(done == mDone, "R3", "done vs model", 64'(done), 64'(mDone));
      check({hi, lo} == mProd, "R7", "register vs model", {hi, lo}, mProd);
    end
  end

  // Starts an operation at the current negedge; returns at the done negedge.
  task automatic runMul(input logic [31:0] a, input logic [31:0] b,
                        input int glitchAt);
    int cyc;
    start = 1'b1; mcandIn = a; mplierIn = b;
    @(negedge clk);
    start = 1'b0; mcandIn = ~a; mplierIn = ~b;
    check(busy == 1'b1, "R2", "busy after load", 64'(busy), 64'd1);
    check(lo == b, "R2", "lo after load", 64'(lo), 64'(b));
    check(hi == 32'd0, "R2", "hi after load", 64'(hi), 64'd0);
    cyc = 0;
    while (!done && cyc < 100) begin
      if (cyc == glitchAt) begin
        start = 1'b1;  // R5: must be ignored
        mcandIn = 32'h1234_5678; mplierIn = 32'h9ABC_DEF0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == 32, "R3", "busy cycles", 64'(cyc), 64'd32);
    check({hi, lo} == {32'd0, a} * {32'd0, b}, (glitchAt >= 0) ? "R5" : "R4",
          "product at done", {hi, lo}, {32'd0, a} * {32'd0, b});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [63:0] held;
    #1;
    check(busy == 0 && done == 0, "R1", "flags in reset", {62'd0, busy, done}, 64'd0);
    check({hi, lo} == 64'd0, "R1", "product in reset", {hi, lo}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R1", "flags after reset", {62'd0, busy, done}, 64'd0);
    check({hi, lo} == 64'd0, "R1", "product after reset", {hi, lo}, 64'd0);

    runMul(32'd2, 32'd6, -1);
    @(negedge clk);
    check(done == 1'b0, "R3", "done single pulse", 64'(done), 64'd0);

    runMul(32'hFFFF_FFFF, 32'hFFFF_FFFF, -1);  // R4 carry case
    @(negedge clk);
    runMul(32'h8000_0001, 32'hDEAD_BEEF, -1);
    @(negedge clk);
    runMul(32'd0, 32'hFFFF_FFFF, -1);
    @(negedge clk);
    runMul(32'hFFFF_FFFF, 32'd1, -1);
    @(negedge clk);

    runMul(32'hCAFE_F00D, 32'h0BAD_1DEA, 5);   // R5 start mid-run
    @(negedge clk);

    // R6: idle with changing operand inputs
    held = {hi, lo};
    for (int i = 0; i < 8; i++) begin
      mcandIn = 32'h1111_1111 * i; mplierIn = ~(32'h0F0F_0F0F * i);
      @(negedge clk);
      check({hi, lo} == held, "R6", "idle hold", {hi, lo}, held);
    end

    // R8: back to back, new start in the done cycle
    runMul(32'h7FFF_FFFF, 32'h0000_0003, -1);
    check(done == 1'b1, "R8", "in done cycle", 64'(done), 64'd1);
    runMul(32'h0001_0000, 32'h0001_0000, -1);
    @(negedge clk);
    runMul(32'hA5A5_A5A5, 32'h5A5A_5A5A, 31);  // R5 start on last busy cycle
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule